// File: doc/BRIEF.md
# Daisy-Chained Interrupt Responder

This block sits on the slave side of a shared interrupt bus. It holds one pending interrupt, requests it on an active-low request output at a level selected by a configuration input, and takes part in acknowledge cycles that travel down a daisy chain. Each acknowledge arrives on `iackin_n` while the address strobe is low and a three-bit level code is on `ack_code`. If the block has a pending request at that level, it answers. It places its status word on the data lanes and pulls `dtack_n` low. If it has no pending request at that level, it passes the acknowledge on to the next module by pulling `iackout_n` low.

The block works out the width of the answer from the bus. A low `lword_n` asks for four bytes. Otherwise, the second data strobe falling within a fixed window after the first asks for two bytes, and a second strobe that does not arrive asks for one byte. If the requested width is wider than the configured status width, the block signals `berr_n` instead of `dtack_n`. In that case it drives no data and keeps its request pending. All bus pins are synchronous active-low levels sampled on `clk`. Tri-state drivers are shown as per-lane output enables.

Every pin is a plain control or status level. The block has no streamed data path, so there is no valid/ready handshake and no back-pressure. The bus master paces each cycle with its strobes.

Top module: `irq_daisy_responder`

## Requirements
- R1: Reset clears the pending flag. A one-cycle pulse on `irq_set` sets it. `irq_n` is low exactly while the flag is set.
- R2: On the first edge that sees `as_n` and `iackin_n` both low, the block selects itself only if it is pending and `ack_code` equals `irq_level`. Otherwise it pulls `iackout_n` low at that edge.
- R3: `iackout_n` falls only while `iackin_n` is low. After it has been low, it returns high at the first edge that sees `as_n` high.
- R4: `data_oe` stays 0 and `dtack_n` stays high unless the block has selected itself, with `iackin_n` low. A forwarding block never drives data and never drives `dtack_n`.
- R5: The block counts edges from the first edge that sees a data strobe low. `dtack_n`/`berr_n` falls at edge j with j >= MIN_ACK. j is the first such edge where either both strobes are low or j = DSB_WAIT.
- R6: Width is decided as follows. `lword_n` low gives 4 bytes. Otherwise, both strobes low at the deciding edge gives 2 bytes; else 1 byte. For n bytes, `data_oe` has its low n bits set and `data_out` carries the low n bytes of `status_id`, with the upper bytes zero.
- R7: If the width exceeds STATUS_BYTES, `berr_n` falls instead of `dtack_n`. `data_oe` stays 0 and the pending flag is kept.
- R8: While `dtack_n` is low, `data_out` stays stable. On the edge that sees both strobes high, `data_oe` clears. `dtack_n`/`berr_n` rise on the following edge.
- R9: A response with `dtack_n` clears the pending flag at the edge where `dtack_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set | input | 1 | Pulse that makes the interrupt pending |
| irq_level | input | 3 | Level this block requests and answers (1..7) |
| status_id | input | 32 | Status/ID word returned on acknowledge |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Data strobe 0 (first strobe), active low |
| ds1_n | input | 1 | Data strobe 1 (second strobe), active low |
| lword_n | input | 1 | Low requests a four-byte status |
| ack_code | input | 3 | Level being acknowledged |
| iackin_n | input | 1 | Daisy-chain acknowledge in, active low |
| irq_n | output | 1 | Interrupt request, active low |
| iackout_n | output | 1 | Daisy-chain acknowledge out, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| data_out | output | 32 | Status/ID on the data lanes |
| data_oe | output | 4 | Per-byte-lane output enable |

## Verification
The bench varies the delay of the second strobe around the window edge, using delays of DSB_WAIT and DSB_WAIT+1. A meter that is off by one returns two bytes where one is due, or the reverse, and the lane enables expose this. Acknowledges that carry the wrong level, arrive with no request pending, or arrive with `iackin_n` held high show whether the block forwards or keeps quiet. A block that answered anyway would drive data or `dtack_n`. Four-byte requests against a two-byte status must produce a bus error with the request still pending. After each release, the bench checks that the data enable clears one cycle before the acknowledge rises. Latency is checked edge by edge against the minimum acknowledge delay.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FWD,
    S_WAIT_DS,
    S_MEASURE,
    S_ACK,
    S_DROP,
    S_WAIT_AS
  } resp_state_t;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } ack_width_t;

  function automatic logic [2:0] width_bytes(input ack_width_t w);
    case (w)
      WID_8:   width_bytes = 3'd1;
      WID_16:  width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  output logic pending_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pending_o <= 1'b0;
    else if (set_i)   pending_o <= 1'b1;
    else if (clear_i) pending_o <= 1'b0;
  end

  assert_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pending_o);
endmodule

// File: rtl/strobe_width_meter.sv
module strobe_width_meter
  import irq_resp_pkg::*;
#(
  parameter int DSB_WAIT = 4,
  parameter int MIN_ACK  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       run_i,
  input  logic       ds0_n,
  input  logic       ds1_n,
  input  logic       lword_n,
  output logic       done_o,
  output ack_width_t width_o
);
  localparam int LIMIT = (DSB_WAIT > MIN_ACK) ? DSB_WAIT : MIN_ACK;
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   elapsed;
  logic             both_low;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 cnt <= '0;
    else if (start_i)                           cnt <= '0;
    else if (run_i && cnt != CNT_W'(LIMIT + 1)) cnt <= cnt + 1'b1;
  end

  assign elapsed  = {1'b0, cnt} + 1'b1;
  assign both_low = !ds0_n && !ds1_n;

  always_comb begin
    done_o = run_i && (elapsed >= (CNT_W+1)'(MIN_ACK)) &&
             (both_low || elapsed >= (CNT_W+1)'(DSB_WAIT));
    if (!lword_n)      width_o = WID_32;
    else if (both_low) width_o = WID_16;
    else               width_o = WID_8;
  end
endmodule

// File: rtl/status_lane_mux.sv
module status_lane_mux
  import irq_resp_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic [8*DATA_BYTES-1:0] status_i,
  input  ack_width_t              width_i,
  output logic [8*DATA_BYTES-1:0] data_o,
  output logic [DATA_BYTES-1:0]   oe_o
);
  logic [2:0] nbytes;
  assign nbytes = width_bytes(width_i);

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    assign oe_o[b]         = (3'(b) < nbytes);
    assign data_o[8*b +: 8] = oe_o[b] ? status_i[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/irq_daisy_responder.sv
module irq_daisy_responder
  import irq_resp_pkg::*;
#(
  parameter int STATUS_BYTES = 2,
  parameter int DSB_WAIT     = 4,
  parameter int MIN_ACK      = 2,
  parameter int DATA_BYTES   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    irq_set,
  input  logic [2:0]              irq_level,
  input  logic [8*DATA_BYTES-1:0] status_id,
  input  logic                    as_n,
  input  logic                    ds0_n,
  input  logic                    ds1_n,
  input  logic                    lword_n,
  input  logic [2:0]              ack_code,
  input  logic                    iackin_n,
  output logic                    irq_n,
  output logic                    iackout_n,
  output logic                    dtack_n,
  output logic                    berr_n,
  output logic [8*DATA_BYTES-1:0] data_out,
  output logic [DATA_BYTES-1:0]   data_oe
);
  localparam int DW = 8 * DATA_BYTES;

  resp_state_t        state;
  logic               pending;
  logic               meas_done;
  ack_width_t         meas_width;
  logic [DW-1:0]      lane_data;
  logic [DATA_BYTES-1:0] lane_oe;
  logic               too_wide;
  logic               good_ack;

  irq_pending_reg u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clear_i(good_ack), .pending_o(pending)
  );

  strobe_width_meter #(.DSB_WAIT(DSB_WAIT), .MIN_ACK(MIN_ACK)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .start_i(state == S_WAIT_DS), .run_i(state == S_MEASURE),
    .ds0_n(ds0_n), .ds1_n(ds1_n), .lword_n(lword_n),
    .done_o(meas_done), .width_o(meas_width)
  );

  status_lane_mux #(.DATA_BYTES(DATA_BYTES)) u_lanes (
    .status_i(status_id), .width_i(meas_width), .data_o(lane_data), .oe_o(lane_oe)
  );

  assign too_wide = width_bytes(meas_width) > 3'(STATUS_BYTES);
  assign good_ack = (state == S_MEASURE) && meas_done && !too_wide;
  assign irq_n    = !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      iackout_n <= 1'b1;
      dtack_n   <= 1'b1;
      berr_n    <= 1'b1;
      data_out  <= '0;
      data_oe   <= '0;
    end else begin
      case (state)
        S_IDLE: if (!as_n && !iackin_n) begin
          if (pending && ack_code == irq_level) state <= S_WAIT_DS;
          else begin
            iackout_n <= 1'b0;
            state     <= S_FWD;
          end
        end
        S_FWD: if (as_n) begin
          iackout_n <= 1'b1;
          state     <= S_IDLE;
        end
        S_WAIT_DS: begin
          if (as_n)                    state <= S_IDLE;
          else if (!ds0_n || !ds1_n)   state <= S_MEASURE;
        end
        S_MEASURE: if (meas_done) begin
          if (too_wide) berr_n <= 1'b0;
          else begin
            dtack_n  <= 1'b0;
            data_out <= lane_data;
            data_oe  <= lane_oe;
          end
          state <= S_ACK;
        end
        S_ACK: if (ds0_n && ds1_n) begin
          data_oe  <= '0;
          data_out <= '0;
          state    <= S_DROP;
        end
        S_DROP: begin
          dtack_n <= 1'b1;
          berr_n  <= 1'b1;
          state   <= S_WAIT_AS;
        end
        default: if (as_n) state <= S_IDLE;
      endcase
    end
  end

  assert_oe_needs_iackin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe != '0) |-> !iackin_n);
  assert_fwd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !iackout_n |-> (data_oe == '0 && dtack_n));
  assert_iackout_after_iackin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iackout_n) |-> !iackin_n);
  assert_iackout_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!iackout_n && as_n) |=> iackout_n);
  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && $past(!dtack_n) && data_oe != '0) |-> $stable(data_out));
  assert_release_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_n) |-> $past(data_oe) == '0);
  assert_ack_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !berr_n));
  assert_berr_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_n |-> (data_oe == '0 && !irq_n));
  assert_clear_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dtack_n) && !$past(irq_set)) |-> irq_n);
endmodule

// File: tb/irq_daisy_responder_tb_top.sv
module irq_daisy_responder_tb_top;
  localparam int SB = 2, DSBW = 4, MINA = 2;

  logic clk = 1'b0, rst_n = 1'b0, irq_set = 1'b0;
  logic [2:0] irq_level = 3'd5, ack_code = 3'd0;
  logic [31:0] status_id = 32'hA1B2C3D4;
  logic as_n = 1, ds0_n = 1, ds1_n = 1, lword_n = 1, iackin_n = 1;
  logic irq_n, iackout_n, dtack_n, berr_n;
  logic [31:0] data_out;
  logic [3:0] data_oe;
  int tests = 0, fails = 0;
  bit model_pend = 0;

  always #4 clk = ~clk;

  irq_daisy_responder #(.STATUS_BYTES(SB), .DSB_WAIT(DSBW), .MIN_ACK(MINA)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .irq_level(irq_level),
    .status_id(status_id), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .lword_n(lword_n), .ack_code(ack_code), .iackin_n(iackin_n),
    .irq_n(irq_n), .iackout_n(iackout_n), .dtack_n(dtack_n), .berr_n(berr_n),
    .data_out(data_out), .data_oe(data_oe));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bytes(input bit lw_low, input int d);
    if (lw_low) return 4;
    return (d <= DSBW) ? 2 : 1;
  endfunction

  function automatic int exp_latency(input int d);
    int j = (d <= DSBW) ? d : DSBW;
    if (j < MINA) j = MINA;
    return j + 1;
  endfunction

  task automatic pulse_set();
    @(negedge clk); irq_set = 1;
    @(negedge clk); irq_set = 0;
    model_pend = 1;
    @(negedge clk);
    chk(irq_n == 1'b0, "R1 irq_n after set", irq_n, 0);
  endtask

  task automatic ack_cycle(input logic [2:0] code, input bit lw_low, input int d, input bit chain_low);
    bit hit = model_pend && code == irq_level && chain_low;
    int nb = exp_bytes(lw_low, d);
    bit berr_exp = nb > SB;
    int cyc = 0;
    logic [31:0] ed;
    logic [3:0] eoe;
    logic [31:0] held;
    @(negedge clk);
    ack_code = code; lword_n = !lw_low; as_n = 0; iackin_n = !chain_low;
    repeat (2) @(negedge clk);
    chk(iackout_n == !(chain_low && !hit), "R2 iackout select", iackout_n, !(chain_low && !hit));
    chk(data_oe == 0 && dtack_n, "R4 quiet before strobe", {data_oe, dtack_n}, 5'b00001);
    ds0_n = 0;
    if (d == 0) ds1_n = 0;
    while (dtack_n && berr_n && cyc < 16) begin
      @(negedge clk); cyc++;
      if (cyc == d) ds1_n = 0;
      if (dtack_n && berr_n)
        chk(data_oe == 0, "R4 no data while waiting", data_oe, 0);
    end
    if (!hit) begin
      chk(dtack_n && berr_n, "R4 forwarder never acks", {dtack_n, berr_n}, 2'b11);
    end else begin
      chk(cyc == exp_latency(d), "R5 ack latency", cyc, exp_latency(d));
      if (berr_exp) begin
        chk(!berr_n && dtack_n && data_oe == 0, "R7 bus error on wide request",
            {berr_n, dtack_n, data_oe}, 6'b010000);
      end else begin
        eoe = (nb == 1) ? 4'b0001 : 4'b0011;
        ed  = (nb == 1) ? {24'h0, status_id[7:0]} : {16'h0, status_id[15:0]};
        chk(!dtack_n && berr_n, "R6 dtack response", {dtack_n, berr_n}, 2'b01);
        chk(data_oe == eoe, "R6 lane enables", data_oe, eoe);
        chk(data_out == ed, "R6 lane data", data_out, ed);
        model_pend = 0;
        chk(irq_n == 1'b1, "R9 pending cleared", irq_n, 1);
      end
      held = data_out;
      repeat (2) @(negedge clk);
      chk(data_out == held && (!dtack_n || !berr_n), "R8 held until strobes high", data_out, held);
    end
    ds0_n = 1; ds1_n = 1;
    @(negedge clk);
    if (hit) chk(data_oe == 0 && (!dtack_n || !berr_n), "R8 data released first",
                 {data_oe, dtack_n & berr_n}, 5'b00000);
    @(negedge clk);
    chk(dtack_n && berr_n && data_oe == 0, "R8 ack released", {dtack_n, berr_n}, 2'b11);
    as_n = 1;
    @(negedge clk);
    chk(iackout_n == 1'b1, "R3 iackout back high", iackout_n, 1);
    iackin_n = 1;
    chk(irq_n == !model_pend, "R1 irq_n tracks pending", irq_n, !model_pend);
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed = $urandom(1234);
    repeat (3) @(negedge clk);
    chk(irq_n && iackout_n && dtack_n && berr_n && data_oe == 0, "R1 reset state",
        {irq_n, iackout_n, dtack_n, berr_n, data_oe}, 8'hF0);
    rst_n = 1;
    ack_cycle(3'd5, 0, 1, 1);            // R2 not pending: forward
    pulse_set();
    ack_cycle(3'd3, 0, 1, 1);            // R2 wrong level: forward
    ack_cycle(3'd5, 0, 2, 0);            // R4 chain high: quiet
    ack_cycle(3'd5, 0, DSBW, 1);         // R6 two bytes at window edge
    pulse_set();
    ack_cycle(3'd5, 0, DSBW + 1, 1);     // R6 one byte past window
    pulse_set();
    ack_cycle(3'd5, 1, 0, 1);            // R7 four bytes -> bus error
    ack_cycle(3'd5, 0, 0, 1);            // R5 simultaneous strobes
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 2) pulse_set();
      irq_level = 3'(1 + $urandom % 7);
      ack_cycle(($urandom % 3 != 0) ? irq_level : 3'(1 + $urandom % 7),
                ($urandom % 4) == 0, int'($urandom % 8), ($urandom % 8) != 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule